// File: doc/BRIEF.md
# Latched Interval Timer

This block is a 16-bit down-counter with a separate 16-bit reload latch. Software reaches it through byte-wide registers on an 8-bit peripheral bus with a 4-bit address. The latch and counter addresses share one write path: a write fills a latch byte. A write to the arming address also copies the complete latch into the counter and starts the count. On reads the same addresses behave differently. One pair of addresses returns the live counter bytes and the other pair returns the latch bytes.

While the timer runs, the counter drops by one on every cycle in which `tick_en` is high. A tick that arrives with the counter at zero is an underflow. An underflow sets the timer flag, which drives `irq`. The `free_run` input decides what happens next. In one-shot mode the timer stops with the counter parked at 0xFFFF. In free-run mode the counter reloads from the latch and keeps counting. The flag clears as a side effect of two accesses: a write of the latch high byte, and a read of the counter low byte.

Top module: `ivl_timer`

## Requirements
- R1: While `rst_n` is low, and after it is released, the latch, counter, running state, flag and `rdata` are all zero, and `irq` is low.
- R2: A write to offset 0x4 or 0x6 changes only bits 7:0 of the latch. It leaves the counter and the flag as they were.
- R3: A write to offset 0x5 or 0x7 stores bits 15:8 of the latch and clears the flag. A write to 0x7 neither loads the counter nor starts the timer.
- R4: A write to offset 0x5 loads the counter with {written byte, latch bits 7:0} and sets the timer running.
- R5: While running, the counter decreases by one on each cycle with `tick_en` high. On other cycles it holds its value.
- R6: A tick while running with the counter at zero sets the flag. After a counter load of N, the flag therefore rises on the (N+1)th tick.
- R7: When `free_run` is 0, an underflow stops the timer and leaves the counter at 0xFFFF. Later ticks do not set the flag again until the next write to 0x5.
- R8: When `free_run` is 1, an underflow reloads the counter from the latch and the timer keeps running. The flag is set again every N+1 ticks.
- R9: A read of offset 0x4 returns counter bits 7:0 and clears the flag. A read of offset 0x5 returns counter bits 15:8 and leaves the flag unchanged.
- R10: Reads of offsets 0x6 and 0x7 return latch bits 7:0 and 15:8 and leave the flag unchanged. A read of any other offset returns 0x00.
- R11: `cs` and `we` are sampled at the rising clock edge. Read data appears on `rdata` after that edge and holds until the next read. A write with `cs` low has no effect.
- R12: An underflow and a flag-clearing access in the same cycle leave the flag set. A write to 0x5 in a cycle with `tick_en` high loads the counter, and that tick is not applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_en | input | 1 | Count enable, one decrement per high cycle |
| free_run | input | 1 | Underflow mode: 1 reloads from the latch, 0 stops |
| cs | input | 1 | Register access select |
| we | input | 1 | 1 for write, 0 for read |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq | output | 1 | Timer flag |

## Verification
The bench targets the off-by-one underflow point. A counter that raised the flag on reaching zero, instead of on the following tick, would signal one tick early and make every free-run period one tick short. It also checks that the two write aliases stay apart. A design that also armed the timer on a 0x7 write would reload the counter and show a new value on the next counter read. The same-cycle collisions get directed cases too. One is a read of 0x4 that coincides with an underflow, where a design that let the clear win would lose an interrupt. The other is an arming write that coincides with a tick, where a design that applied the tick would read back one less than the loaded value.

// File: rtl/ivl_timer_pkg.sv
`timescale 1ns/1ps
package ivl_timer_pkg;
  // Register offsets; the low/high pairing is decoded by the register block
  localparam int unsigned OFS_CNT_LO = 4;
  localparam int unsigned OFS_CNT_HI = 5;
  localparam int unsigned OFS_LAT_LO = 6;
  localparam int unsigned OFS_LAT_HI = 7;

  typedef struct packed {
    logic lat_lo_wr;   // latch bits 7:0 written
    logic lat_hi_wr;   // latch bits 15:8 written (clears flag)
    logic start;       // counter load and arm
    logic cnt_lo_rd;   // counter low read (clears flag)
  } bus_ev_t;
endpackage

// File: rtl/ivl_timer_rst_sync.sv
`timescale 1ns/1ps
module ivl_timer_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= 1'b0;
        else        sh_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_s_n = sh_q[STAGES-1];
endmodule

// File: rtl/ivl_timer_regs.sv
`timescale 1ns/1ps
module ivl_timer_regs
  import ivl_timer_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output bus_ev_t           ev_o,
  output logic [CNT_W-1:0]  lat_o,
  output logic [CNT_W-1:0]  lat_nxt_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned LANES = CNT_W / DATA_W;

  logic              wr_acc, rd_acc;
  logic              hit_cl, hit_ch, hit_ll, hit_lh;
  bus_ev_t           ev;
  logic [LANES-1:0]  lane_we;
  logic [CNT_W-1:0]  lat_q, lat_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;

  // Decode
  always_comb begin
    wr_acc = cs_i && we_i;
    rd_acc = cs_i && !we_i;
    hit_cl = (addr_i == ADDR_W'(OFS_CNT_LO));
    hit_ch = (addr_i == ADDR_W'(OFS_CNT_HI));
    hit_ll = (addr_i == ADDR_W'(OFS_LAT_LO));
    hit_lh = (addr_i == ADDR_W'(OFS_LAT_HI));
    ev.lat_lo_wr = wr_acc && (hit_cl || hit_ll);
    ev.lat_hi_wr = wr_acc && (hit_ch || hit_lh);
    ev.start     = wr_acc && hit_ch;
    ev.cnt_lo_rd = rd_acc && hit_cl;
  end

  assign lane_we = {ev.lat_hi_wr, ev.lat_lo_wr};

  // Latch byte lanes
  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lat_d[g*DATA_W +: DATA_W] =
        lane_we[g] ? wdata_i : lat_q[g*DATA_W +: DATA_W];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               lat_q <= '0;
    else if (|lane_we)        lat_q <= lat_d;
  end

  // Read mux, registered
  always_comb begin
    rdata_d = '0;
    if (hit_cl)      rdata_d = cnt_i[DATA_W-1:0];
    else if (hit_ch) rdata_d = cnt_i[CNT_W-1:DATA_W];
    else if (hit_ll) rdata_d = lat_q[DATA_W-1:0];
    else if (hit_lh) rdata_d = lat_q[CNT_W-1:DATA_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (rd_acc) rdata_q <= rdata_d;
  end

  assign ev_o      = ev;
  assign lat_o     = lat_q;
  assign lat_nxt_o = lat_d;
  assign rdata_o   = rdata_q;
endmodule

// File: rtl/ivl_timer_core.sv
`timescale 1ns/1ps
module ivl_timer_core
  import ivl_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             free_run_i,
  input  bus_ev_t          ev_i,
  input  logic [CNT_W-1:0] lat_i,
  input  logic [CNT_W-1:0] lat_nxt_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o,
  output logic             flag_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             flag_q, flag_d;
  logic             step, uflow, cnt_en;

  always_comb begin
    step   = run_q && tick_i;
    uflow  = step && (cnt_q == '0);
    cnt_d  = cnt_q;
    run_d  = run_q;
    if (ev_i.start) begin
      cnt_d = lat_nxt_i;
      run_d = 1'b1;
    end else if (step) begin
      if (cnt_q == '0) begin
        if (free_run_i) begin
          cnt_d = lat_i;
        end else begin
          cnt_d = '1;
          run_d = 1'b0;
        end
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
    cnt_en = ev_i.start || step;

    flag_d = flag_q;
    if (uflow)                                flag_d = 1'b1;
    else if (ev_i.lat_hi_wr || ev_i.cnt_lo_rd) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign cnt_o  = cnt_q;
  assign run_o  = run_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/ivl_timer.sv
`timescale 1ns/1ps
module ivl_timer
  import ivl_timer_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CNT_W      = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              free_run,
  input  logic              cs,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic             rst_s_n;
  bus_ev_t          ev_w;
  logic [CNT_W-1:0] lat_w, lat_nxt_w, cnt_w;
  logic             run_w, flag_w;

  ivl_timer_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  ivl_timer_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .cs_i      (cs),
    .we_i      (we),
    .addr_i    (addr),
    .wdata_i   (wdata),
    .cnt_i     (cnt_w),
    .ev_o      (ev_w),
    .lat_o     (lat_w),
    .lat_nxt_o (lat_nxt_w),
    .rdata_o   (rdata)
  );

  ivl_timer_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .tick_i     (tick_en),
    .free_run_i (free_run),
    .ev_i       (ev_w),
    .lat_i      (lat_w),
    .lat_nxt_i  (lat_nxt_w),
    .cnt_o      (cnt_w),
    .run_o      (run_w),
    .flag_o     (flag_w)
  );

  assign irq = flag_w;
endmodule

// File: rtl/ivl_timer_chk.sv
`timescale 1ns/1ps
module ivl_timer_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned CNT_W = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst_s_n,
  input logic              tick,
  input logic              free_run,
  input logic              cs,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  lat,
  input logic              run,
  input logic              flag
);
  logic arm, hi_wr, lo_wr, uf;
  assign arm   = cs && we && (addr == ADDR_W'(5));
  assign hi_wr = cs && we && (addr == ADDR_W'(5) || addr == ADDR_W'(7));
  assign lo_wr = cs && we && (addr == ADDR_W'(4) || addr == ADDR_W'(6));
  assign uf    = run && tick && (cnt == '0);

  // R4
  arm_load_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    arm |=> (run && cnt == {$past(wdata), $past(lat[DATA_W-1:0])}));

  // R5
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (run && tick && cnt != '0 && !arm) |=> (cnt == $past(cnt) - 1'b1));

  // R6
  underflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    uf |=> flag);

  // R7
  one_shot_stop_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (uf && !free_run && !arm) |=> (!run && cnt == '1));

  // R8
  free_reload_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (uf && free_run && !arm) |=> (run && cnt == $past(lat)));

  // R3
  high_write_clear_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (hi_wr && !uf) |=> !flag);

  // R2
  low_write_keep_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (lo_wr && !run) |=> $stable(cnt));
endmodule

bind ivl_timer ivl_timer_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_s_n  (rst_s_n),
  .tick     (tick_en),
  .free_run (free_run),
  .cs       (cs),
  .we       (we),
  .addr     (addr),
  .wdata    (wdata),
  .cnt      (cnt_w),
  .lat      (lat_w),
  .run      (run_w),
  .flag     (flag_w)
);

// File: tb/ivl_timer_bench.sv
`timescale 1ns/1ps
module ivl_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_en, free_run, cs, we;
  logic [3:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // Reference state
  logic [15:0] m_lat, m_cnt;
  logic        m_run, m_flag;
  logic [7:0]  last_rd;

  always #4 clk = ~clk;

  ivl_timer u_ivl_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .free_run(free_run),
    .cs(cs), .we(we), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [3:0] a);
    case (a)
      4'h4:    return m_cnt[7:0];
      4'h5:    return m_cnt[15:8];
      4'h6:    return m_lat[7:0];
      4'h7:    return m_lat[15:8];
      default: return 8'h00;
    endcase
  endfunction

  // One clock cycle of stimulus, model update and comparison
  task automatic cyc(input logic c, input logic w, input logic [3:0] a,
                     input logic [7:0] d, input logic t, input string tag);
    logic [7:0]  erd;
    logic        wr, rd, uf, st;
    logic [15:0] nlat, ncnt;
    logic        nrun, nflag;
    cs = c; we = w; addr = a; wdata = d; tick_en = t;
    wr = c && w; rd = c && !w;
    erd = exp_read(a);
    uf  = m_run && t && (m_cnt == 16'h0);
    st  = wr && (a == 4'h5);
    nlat = m_lat;
    if (wr && (a == 4'h4 || a == 4'h6)) nlat[7:0]  = d;
    if (wr && (a == 4'h5 || a == 4'h7)) nlat[15:8] = d;
    ncnt = m_cnt; nrun = m_run;
    if (st) begin ncnt = nlat; nrun = 1'b1; end
    else if (m_run && t) begin
      if (m_cnt == 16'h0) begin
        if (free_run) ncnt = m_lat;
        else begin ncnt = 16'hFFFF; nrun = 1'b0; end
      end else ncnt = m_cnt - 16'h1;
    end
    nflag = m_flag;
    if (uf) nflag = 1'b1;
    else if ((wr && (a == 4'h5 || a == 4'h7)) || (rd && a == 4'h4)) nflag = 1'b0;
    @(posedge clk);
    m_lat = nlat; m_cnt = ncnt; m_run = nrun; m_flag = nflag;
    @(negedge clk);
    if (rd) begin
      last_rd = rdata;
      check({8'h0, rdata}, {8'h0, erd}, tag);
    end
    check({15'h0, irq}, {15'h0, m_flag}, tag);
    cs = 1'b0; we = 1'b0; tick_en = 1'b0;
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d, input string tag);
    cyc(1'b1, 1'b1, a, d, 1'b0, tag);
  endtask

  task automatic rd_reg(input logic [3:0] a, input logic [7:0] exp, input string tag);
    cyc(1'b1, 1'b0, a, 8'h00, 1'b0, tag);
    check({8'h0, last_rd}, {8'h0, exp}, tag);
  endtask

  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 4'h0, 8'h00, 1'b1, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick_en = 1'b0; free_run = 1'b0; cs = 1'b0; we = 1'b0;
    addr = 4'h0; wdata = 8'h00;
    m_lat = 16'h0; m_cnt = 16'h0; m_run = 1'b0; m_flag = 1'b0; last_rd = 8'h0;
    repeat (4) @(negedge clk);
    check({15'h0, irq}, 16'h0, "R1 irq in reset");
    check({8'h0, rdata}, 16'h0, "R1 rdata in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state through the bus
    rd_reg(4'h4, 8'h00, "R1");
    rd_reg(4'h5, 8'h00, "R1");
    rd_reg(4'h6, 8'h00, "R1");
    rd_reg(4'h7, 8'h00, "R1");

    // R4 load and arm, R10 latch readback, R9 counter readback
    wr_reg(4'h4, 8'h34, "R2");
    wr_reg(4'h5, 8'h12, "R4");
    rd_reg(4'h6, 8'h34, "R10");
    rd_reg(4'h7, 8'h12, "R10");
    rd_reg(4'h5, 8'h12, "R9");
    rd_reg(4'h4, 8'h34, "R9");
    // R2 low-byte write leaves counter alone
    wr_reg(4'h6, 8'h55, "R2");
    rd_reg(4'h4, 8'h34, "R2");
    rd_reg(4'h6, 8'h55, "R2");
    // R3 write to 0x7 does not reload
    wr_reg(4'h7, 8'h00, "R3");
    rd_reg(4'h5, 8'h12, "R3");

    // One-shot: R5 R6 R7
    free_run = 1'b0;
    wr_reg(4'h4, 8'h03, "R4");
    wr_reg(4'h5, 8'h00, "R4");
    ticks(3, "R5");
    check({15'h0, irq}, 16'h0, "R6 no flag at zero");
    rd_reg(4'h4, 8'h00, "R5");
    ticks(1, "R6");
    check({15'h0, irq}, 16'h1, "R6 flag on N+1 tick");
    rd_reg(4'h5, 8'hFF, "R7");
    check({15'h0, irq}, 16'h1, "R9 high read keeps flag");
    rd_reg(4'h6, 8'h03, "R10");
    check({15'h0, irq}, 16'h1, "R10 latch read keeps flag");
    rd_reg(4'h0, 8'h00, "R10");
    rd_reg(4'h4, 8'hFF, "R9");
    check({15'h0, irq}, 16'h0, "R9 low read clears flag");
    ticks(5, "R7");
    check({15'h0, irq}, 16'h0, "R7 no second flag");
    rd_reg(4'h4, 8'hFF, "R7");

    // Free-run: R8
    free_run = 1'b1;
    wr_reg(4'h4, 8'h02, "R8");
    wr_reg(4'h5, 8'h00, "R8");
    ticks(3, "R8");
    check({15'h0, irq}, 16'h1, "R8 first period");
    rd_reg(4'h4, 8'h02, "R8");
    ticks(3, "R8");
    check({15'h0, irq}, 16'h1, "R8 second period");
    wr_reg(4'h7, 8'h00, "R3");
    check({15'h0, irq}, 16'h0, "R3 high write clears flag");

    // R11 write with cs low ignored
    cyc(1'b0, 1'b1, 4'h6, 8'hAA, 1'b0, "R11");
    rd_reg(4'h6, 8'h02, "R11");

    // R12 collisions
    ticks(2, "R12");
    cyc(1'b1, 1'b0, 4'h4, 8'h00, 1'b1, "R12");
    check({15'h0, irq}, 16'h1, "R12 set beats clear");
    cyc(1'b1, 1'b1, 4'h5, 8'h00, 1'b1, "R12");
    rd_reg(4'h4, 8'h02, "R12 load beats tick");

    // Constrained random
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 4000; i++) begin
      int op;
      logic [3:0] a;
      logic [7:0] d;
      if (i % 500 == 0) free_run = $urandom_range(0, 1) == 1;
      op = $urandom_range(0, 9);
      if (op < 5) begin
        cyc(1'b0, 1'b0, 4'h0, 8'h00, 1'($urandom_range(0, 1)), "random");
      end else begin
        a = (op == 9) ? 4'($urandom_range(0, 15)) : 4'($urandom_range(4, 7));
        d = (a == 4'h5 || a == 4'h7) ? 8'($urandom_range(0, 1)) : 8'($urandom_range(0, 12));
        cyc(1'($urandom_range(0, 7) != 0), 1'($urandom_range(0, 1)), a, d,
            1'($urandom_range(0, 1)), "random");
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule